// File: doc/BRIEF.md
# Block-Segmented Cartridge-to-RAM Copy Engine

This engine moves a run of bytes from a cartridge ROM, read 16 bits at a time, into a byte-addressed RAM. It stages the data in an internal 128-byte buffer, one block at a time. For each block it first fetches ROM words into the buffer. It then writes the buffered bytes to RAM one per handshake. A one-cycle start pulse gives the RAM start address, the ROM start address and a 24-bit length field. When the last block has been written back, a one-cycle done pulse reports completion. The ROM and RAM addresses reached at the end are presented so that a register file can refresh its copies.

When the RAM start address is not a multiple of 8, the first block is shortened so that the next block lands on an 8-byte boundary. That first block also carries two flaws, and the engine reproduces both deliberately. The first is an off-by-one that lengthens an odd block by one byte. The second cuts the written byte count by the misalignment, which leaves a hole in RAM at the end of the first block. Bytes read from at or beyond the configured ROM size are replaced with 0xFF.

Both memory ports are valid/ready. A request or write beat moves on a rising clock edge at which valid and ready are both high. Once valid is raised, it stays high with its address and data unchanged until ready is seen. The slave may hold ready low for any number of cycles, and the engine simply waits. No output depends combinationally on a ready input. The ROM response port accepts data only while `rsp_ready_o` is high, and only one word read is outstanding at any time.

Top module: `romdma_engine`

## Requirements
- R1: The byte count is the length field plus one. The RAM start address keeps only bits 22:1 and the ROM start address keeps only bits 27:1; all other bits are cleared.
- R2: Each block's misalignment is the RAM address bits 2:0, and its cap is 128 minus that misalignment. The block length is the lesser of the remaining count and the cap.
- R3: ROM is read as 16-bit words at even byte addresses, big-endian, with the high byte at the even address. A block fetches its length rounded up to even, and the ROM address advances by that fetch count.
- R4: After each block the remaining count drops by the block length. If the result is odd, one is added to it.
- R5: In the first block only, a block length equal to the cap minus one is raised by one before writeback.
- R6: In the first block only, the RAM write count is the (R5-adjusted) length minus the misalignment, floored at zero. Buffer byte i is always written to RAM address plus i.
- R7: After each block, the RAM address advances by the bytes written and is then rounded up to a multiple of 8. The final RAM and ROM addresses are presented on the final-address outputs when done is high.
- R8: Any byte whose ROM byte address is at or above the ROM size input reads as 0xFF.
- R9: Start is accepted only while busy is low. A start pulse during a transfer has no effect on its writes, its final addresses or its done count.
- R10: After reset, busy, done and both valids are low. Busy stays high from the accepted start until done. Done is high for exactly one cycle, after the last RAM write.
- R11: A request valid or write valid that is not accepted stays high with a stable address (and stable data) on the next cycle. The ROM response is accepted only while no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| ram_addr_i | input | 24 | RAM start address |
| rom_addr_i | input | 32 | ROM start address |
| len_i | input | 24 | Length field (bytes minus one) |
| rom_size_i | input | 32 | ROM size in bytes |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ram_final_o | output | 24 | RAM address reached at the end |
| rom_final_o | output | 32 | ROM address reached at the end |
| rom_req_valid_o | output | 1 | ROM word read request valid |
| rom_req_ready_i | input | 1 | ROM request accepted |
| rom_req_addr_o | output | 32 | ROM byte address of the word (even) |
| rom_rsp_valid_i | input | 1 | ROM read data valid |
| rom_rsp_ready_o | output | 1 | Engine waiting for read data |
| rom_rsp_data_i | input | 16 | ROM word, high byte at even address |
| ram_wr_valid_o | output | 1 | RAM byte write valid |
| ram_wr_ready_i | input | 1 | RAM write accepted |
| ram_wr_addr_o | output | 24 | RAM byte address |
| ram_wr_data_o | output | 8 | RAM byte data |

## Verification
A wrong block length or a wrong remaining count shows up at the RAM in the same block. Bytes appear where a hole belongs, or a hole appears where bytes belong, and the bench catches this by comparing the whole RAM image at done. A wrong RAM or ROM address update stays hidden until the next block starts. It then shifts every later byte and leaves the final-address outputs wrong at done. A mistake in the first-block quirks only affects the few bytes at the end of block one, so misaligned starts of 2, 4 and 6 are exercised with lengths near the cap and below the misalignment. Handshake and pulse faults are caught within one cycle of the faulty edge.

// File: rtl/romdma_pkg.sv
package romdma_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PLAN,
    S_REQ,
    S_RSP,
    S_WRITE,
    S_BLKEND,
    S_FINISH
  } dma_state_e;

  // Keep address bits hi..1, clear bit 0 and everything above hi.
  function automatic logic [31:0] keep_mask(input int hi);
    logic [31:0] m;
    m = '0;
    for (int b = 1; b <= hi; b++) m[b] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/romdma_block_plan.sv
module romdma_block_plan #(
  parameter int BLK_BYTES = 128,
  parameter int REM_W     = 25,
  localparam int CW       = $clog2(BLK_BYTES) + 1
) (
  input  logic [REM_W-1:0] rem_i,
  input  logic [2:0]       mis_i,
  input  logic             first_i,
  output logic [CW-1:0]    cur_o,
  output logic [CW-1:0]    fetch_o,
  output logic [CW-1:0]    wr_o,
  output logic [REM_W-1:0] rem_next_o
);

  logic [CW-1:0]    cap;
  logic [CW-1:0]    adj;
  logic [REM_W-1:0] rem_sub;

  always_comb begin
    cap = CW'(BLK_BYTES) - CW'(mis_i);
    if (rem_i < REM_W'(cap)) cur_o = rem_i[CW-1:0];
    else                     cur_o = cap;

    // ROM side moves whole 16-bit words
    fetch_o = cur_o + CW'(cur_o[0]);

    rem_sub    = rem_i - REM_W'(cur_o);
    rem_next_o = rem_sub + REM_W'(rem_sub[0]);

    // first-block quirks: off-by-one, then misalignment underrun
    adj = cur_o;
    if (first_i && (cur_o == cap - CW'(1))) adj = cur_o + CW'(1);
    if (!first_i)                    wr_o = adj;
    else if (adj > CW'(mis_i))       wr_o = adj - CW'(mis_i);
    else                             wr_o = '0;
  end

endmodule

// File: rtl/romdma_stage_buf.sv
module romdma_stage_buf #(
  parameter int DEPTH   = 128,
  localparam int WORDS  = DEPTH / 2,
  localparam int IW     = $clog2(WORDS),
  localparam int BW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [15:0]   wdata_i,
  input  logic [BW-1:0] ridx_i,
  output logic [7:0]    rdata_o
);

  logic [7:0] mem_q [DEPTH];

  // lane 0 = high byte (even address), lane 1 = low byte
  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we_i) mem_q[{widx_i, 1'(g)}] <= wdata_i[15-8*g -: 8];
    end
  end

  assign rdata_o = mem_q[ridx_i];

endmodule

// File: rtl/romdma_engine.sv
module romdma_engine #(
  parameter int BLK_BYTES  = 128,
  parameter int RAM_AW     = 24,
  parameter int ROM_AW     = 32,
  parameter int LEN_W      = 24,
  parameter int RAM_KEEP_HI = 22,
  parameter int ROM_KEEP_HI = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [RAM_AW-1:0] ram_addr_i,
  input  logic [ROM_AW-1:0] rom_addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ROM_AW-1:0] rom_size_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [RAM_AW-1:0] ram_final_o,
  output logic [ROM_AW-1:0] rom_final_o,
  output logic              rom_req_valid_o,
  input  logic              rom_req_ready_i,
  output logic [ROM_AW-1:0] rom_req_addr_o,
  input  logic              rom_rsp_valid_i,
  output logic              rom_rsp_ready_o,
  input  logic [15:0]       rom_rsp_data_i,
  output logic              ram_wr_valid_o,
  input  logic              ram_wr_ready_i,
  output logic [RAM_AW-1:0] ram_wr_addr_o,
  output logic [7:0]        ram_wr_data_o
);
  import romdma_pkg::*;

  localparam int CW    = $clog2(BLK_BYTES) + 1;
  localparam int REM_W = LEN_W + 1;
  localparam int WORDS = BLK_BYTES / 2;
  localparam int WIW   = $clog2(WORDS) + 1;
  localparam logic [31:0] RAM_M32 = keep_mask(RAM_KEEP_HI);
  localparam logic [31:0] ROM_M32 = keep_mask(ROM_KEEP_HI);
  localparam logic [RAM_AW-1:0] RAM_MASK = RAM_M32[RAM_AW-1:0];
  localparam logic [ROM_AW-1:0] ROM_MASK = ROM_M32[ROM_AW-1:0];

  dma_state_e        state_q;
  logic [RAM_AW-1:0] ram_q;
  logic [ROM_AW-1:0] rom_q;
  logic [REM_W-1:0]  rem_q;
  logic              first_q;
  logic [CW-1:0]     blk_fetch_q, blk_wr_q;
  logic [REM_W-1:0]  blk_rem_q;
  logic [WIW-1:0]    widx_q;
  logic [CW-1:0]     wcnt_q;

  logic [CW-1:0]     p_cur, p_fetch, p_wr;
  logic [REM_W-1:0]  p_rem_next;

  romdma_block_plan #(.BLK_BYTES(BLK_BYTES), .REM_W(REM_W)) plan_i (
    .rem_i      (rem_q),
    .mis_i      (ram_q[2:0]),
    .first_i    (first_q),
    .cur_o      (p_cur),
    .fetch_o    (p_fetch),
    .wr_o       (p_wr),
    .rem_next_o (p_rem_next)
  );

  // ROM word address and out-of-range byte substitution
  logic [ROM_AW-1:0] word_addr;
  logic              hi_oob, lo_oob;
  logic [15:0]       fill_word;
  logic              buf_we;
  logic              last_word;
  logic [RAM_AW-1:0] ram_sum;

  always_comb begin
    word_addr = rom_q + ROM_AW'({widx_q, 1'b0});
    hi_oob    = word_addr >= rom_size_i;
    lo_oob    = ({1'b0, word_addr} + (ROM_AW+1)'(1)) >= {1'b0, rom_size_i};
    fill_word = {hi_oob ? 8'hFF : rom_rsp_data_i[15:8],
                 lo_oob ? 8'hFF : rom_rsp_data_i[7:0]};
    buf_we    = (state_q == S_RSP) && rom_rsp_valid_i;
    last_word = (widx_q + WIW'(1)) == WIW'(blk_fetch_q >> 1);
    ram_sum   = ram_q + RAM_AW'(blk_wr_q);
  end

  romdma_stage_buf #(.DEPTH(BLK_BYTES)) buf_i (
    .clk     (clk),
    .we_i    (buf_we),
    .widx_i  (widx_q[WIW-2:0]),
    .wdata_i (fill_word),
    .ridx_i  (wcnt_q[CW-2:0]),
    .rdata_o (ram_wr_data_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      ram_q       <= '0;
      rom_q       <= '0;
      rem_q       <= '0;
      first_q     <= 1'b0;
      blk_fetch_q <= '0;
      blk_wr_q    <= '0;
      blk_rem_q   <= '0;
      widx_q      <= '0;
      wcnt_q      <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          ram_q   <= ram_addr_i & RAM_MASK;
          rom_q   <= rom_addr_i & ROM_MASK;
          rem_q   <= REM_W'(len_i) + REM_W'(1);
          first_q <= 1'b1;
          state_q <= S_PLAN;
        end
        S_PLAN: begin
          blk_fetch_q <= p_fetch;
          blk_wr_q    <= p_wr;
          blk_rem_q   <= p_rem_next;
          widx_q      <= '0;
          wcnt_q      <= '0;
          state_q     <= S_REQ;
        end
        S_REQ: if (rom_req_ready_i) state_q <= S_RSP;
        S_RSP: if (rom_rsp_valid_i) begin
          widx_q <= widx_q + WIW'(1);
          if (last_word) begin
            rom_q   <= rom_q + ROM_AW'(blk_fetch_q);
            state_q <= (blk_wr_q == '0) ? S_BLKEND : S_WRITE;
          end else begin
            state_q <= S_REQ;
          end
        end
        S_WRITE: if (ram_wr_ready_i) begin
          wcnt_q <= wcnt_q + CW'(1);
          if (wcnt_q + CW'(1) == blk_wr_q) state_q <= S_BLKEND;
        end
        S_BLKEND: begin
          ram_q   <= (ram_sum + RAM_AW'(7)) & ~RAM_AW'(7);
          rem_q   <= blk_rem_q;
          first_q <= 1'b0;
          state_q <= (blk_rem_q == '0) ? S_FINISH : S_PLAN;
        end
        S_FINISH: state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o          = state_q != S_IDLE;
  assign done_o          = state_q == S_FINISH;
  assign ram_final_o     = ram_q;
  assign rom_final_o     = rom_q;
  assign rom_req_valid_o = state_q == S_REQ;
  assign rom_req_addr_o  = word_addr;
  assign rom_rsp_ready_o = state_q == S_RSP;
  assign ram_wr_valid_o  = state_q == S_WRITE;
  assign ram_wr_addr_o   = ram_q + RAM_AW'(wcnt_q);

  // ---------------- assertions ----------------
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_req_valid_o && !rom_req_ready_i) |=> (rom_req_valid_o && $stable(rom_req_addr_o)));

  p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr_valid_o && !ram_wr_ready_i) |=>
      (ram_wr_valid_o && $stable(ram_wr_addr_o) && $stable(ram_wr_data_o)));

  p_rsp_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rsp_ready_o |-> !rom_req_valid_o);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  p_word_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req_valid_o |-> (rom_req_addr_o[0] == 1'b0));

  p_later_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PLAN && !first_q) |-> (ram_q[2:0] == 3'd0));

  p_write_in_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_valid_o |-> (wcnt_q < blk_wr_q && blk_wr_q <= CW'(BLK_BYTES)));

  p_cur_le_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PLAN) |-> (p_cur <= CW'(BLK_BYTES) - CW'(ram_q[2:0]) && p_cur != '0));

endmodule

// File: tb/romdma_engine_tb_top.sv
module romdma_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] ram_addr_i = '0;
  logic [31:0] rom_addr_i = '0;
  logic [23:0] len_i = '0;
  logic [31:0] rom_size_i = 32'h0010_0000;
  logic        busy_o, done_o;
  logic [23:0] ram_final_o;
  logic [31:0] rom_final_o;
  logic        rom_req_valid_o;
  logic        rom_req_ready_i = 1'b0;
  logic [31:0] rom_req_addr_o;
  logic        rom_rsp_valid_i = 1'b0;
  logic        rom_rsp_ready_o;
  logic [15:0] rom_rsp_data_i = '0;
  logic        ram_wr_valid_o;
  logic        ram_wr_ready_i = 1'b0;
  logic [23:0] ram_wr_addr_o;
  logic [7:0]  ram_wr_data_o;

  always #2 clk = ~clk;

  romdma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .ram_addr_i(ram_addr_i), .rom_addr_i(rom_addr_i), .len_i(len_i),
    .rom_size_i(rom_size_i), .busy_o(busy_o), .done_o(done_o),
    .ram_final_o(ram_final_o), .rom_final_o(rom_final_o),
    .rom_req_valid_o(rom_req_valid_o), .rom_req_ready_i(rom_req_ready_i),
    .rom_req_addr_o(rom_req_addr_o), .rom_rsp_valid_i(rom_rsp_valid_i),
    .rom_rsp_ready_o(rom_rsp_ready_o), .rom_rsp_data_i(rom_rsp_data_i),
    .ram_wr_valid_o(ram_wr_valid_o), .ram_wr_ready_i(ram_wr_ready_i),
    .ram_wr_addr_o(ram_wr_addr_o), .ram_wr_data_o(ram_wr_data_o)
  );

  localparam int MEM_N = 2048;
  logic [7:0] mem   [MEM_N];
  logic [7:0] exp_m [MEM_N];
  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  function automatic logic [7:0] rom_byte(input logic [31:0] a);
    return a[7:0] ^ 8'h5A ^ (a[15:8] * 8'd3);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // ROM and RAM slave models: drive at negedge, predict the fire at next posedge
  initial begin
    int  cyc = 0;
    bit  req_fired = 0, rsp_taken = 0;
    logic [31:0] fired_addr = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rsp_taken) begin rom_rsp_valid_i = 1'b0; rsp_taken = 0; end
      if (req_fired) begin
        rom_rsp_valid_i = 1'b1;
        rom_rsp_data_i  = {rom_byte(fired_addr), rom_byte(fired_addr + 1)};
        req_fired = 0;
      end
      rom_req_ready_i = (cyc % 3) != 1;
      ram_wr_ready_i  = (cyc % 4) != 2;
      #1;
      if (rom_req_valid_o && rom_req_ready_i) begin
        req_fired = 1; fired_addr = rom_req_addr_o;
      end
      if (rom_rsp_valid_i && rom_rsp_ready_o) rsp_taken = 1;
      if (ram_wr_valid_o && ram_wr_ready_i) mem[ram_wr_addr_o[10:0]] = ram_wr_data_o;
    end
  end

  // Expected RAM image and final addresses, from the requirements
  task automatic ref_xfer(input logic [23:0] ra, input logic [31:0] rc,
                          input logic [23:0] lf, input logic [31:0] sz,
                          output logic [23:0] ram_f, output logic [31:0] rom_f);
    longint r, c, rem, mis, cap, cur, fetch;
    bit first;
    r = ra & 24'h7FFFFE;             // R1
    c = rc & 32'h0FFFFFFE;
    rem = longint'(lf) + 1;
    first = 1;
    while (rem > 0) begin
      mis = r & 7;                   // R2
      cap = 128 - mis;
      cur = (rem < cap) ? rem : cap;
      fetch = (cur + 1) & ~64'd1;    // R3
      rem = rem - cur;               // R4
      if (rem & 1) rem = rem + 1;
      if (first) begin
        if (cur == cap - 1) cur = cur + 1;   // R5
        cur = cur - mis;                     // R6
        if (cur < 0) cur = 0;
      end
      for (longint i = 0; i < cur; i++)
        exp_m[(r + i) & (MEM_N - 1)] =
          ((c + i) >= longint'(sz)) ? 8'hFF : rom_byte(32'(c + i)); // R8
      c = c + fetch;
      r = (r + cur + 7) & ~64'd7;    // R7
      first = 0;
    end
    ram_f = 24'(r);
    rom_f = 32'(c);
  endtask

  task automatic run_xfer(input string tag, input logic [23:0] ra, input logic [31:0] rc,
                          input logic [23:0] lf, input logic [31:0] sz, input bit restart);
    logic [23:0] er; logic [31:0] ec;
    int seen = 0, mism = 0, first_bad = -1, n = 0;
    ref_xfer(ra, rc, lf, sz, er, ec);
    @(negedge clk);
    rom_size_i = sz; ram_addr_i = ra; rom_addr_i = rc; len_i = lf; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (seen == 0 && n < 20000) begin
      n++;
      if (restart && n == 10) begin
        chk(busy_o, "R9", {tag, " busy before restart"}, busy_o, 1);
        ram_addr_i = 24'h000700; rom_addr_i = 32'h0; len_i = 24'd40; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
      end else begin
        @(negedge clk);
      end
      #2;
      if (done_o) begin
        seen++;
        chk(ram_final_o == er, "R7", {tag, " final ram addr"}, ram_final_o, er);
        chk(rom_final_o == ec, "R3", {tag, " final rom addr"}, rom_final_o, ec);
      end
    end
    chk(seen == 1, "R10", {tag, " done seen"}, seen, 1);
    @(negedge clk); #2;
    chk(!done_o && !busy_o, "R10", {tag, " done one cycle, idle after"},
        {done_o, busy_o}, 0);
    for (int i = 0; i < MEM_N; i++)
      if (mem[i] !== exp_m[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    chk(mism == 0, "R6", {tag, " ram image"},
        (first_bad < 0) ? 0 : mem[first_bad], (first_bad < 0) ? 0 : exp_m[first_bad]);
    if (mism != 0) $display("  %s: %0d bytes differ, first at %0h", tag, mism, first_bad);
  endtask

  task automatic t_reset;
    #1;
    chk(!busy_o && !done_o, "R10", "reset busy/done", {busy_o, done_o}, 0);
    chk(!rom_req_valid_o && !ram_wr_valid_o, "R10", "reset valids",
        {rom_req_valid_o, ram_wr_valid_o}, 0);
  endtask

  // R1 R2 R3: aligned, even length
  task automatic t_aligned;   run_xfer("R2 aligned", 24'h000040, 32'h100, 24'd15, 32'h100000, 0); endtask
  // R1 masking of high and low address bits, R3 odd fetch rounding
  task automatic t_mask;      run_xfer("R1 mask", 24'h800741, 32'hF000_0301, 24'd6, 32'h100000, 0); endtask
  // R4: odd count rounding across blocks
  task automatic t_multi;     run_xfer("R4 multi", 24'h000100, 32'h400, 24'd298, 32'h100000, 0); endtask
  // R6: misaligned start leaves a hole, second block aligned
  task automatic t_mis;       run_xfer("R6 mis2", 24'h000302, 32'h800, 24'd130, 32'h100000, 0); endtask
  // R5: length equal to cap minus one on first block
  task automatic t_offbyone;  run_xfer("R5 offby1", 24'h000406, 32'h900, 24'd120, 32'h100000, 0); endtask
  // R6: write count floors at zero
  task automatic t_floor;     run_xfer("R6 floor", 24'h000504, 32'hA00, 24'd2, 32'h100000, 0); endtask
  // R8: bytes past the ROM size read as 0xFF
  task automatic t_oob;       run_xfer("R8 oob", 24'h000600, 32'h1008, 24'd30, 32'h1011, 0); endtask
  // R9: start while busy is ignored
  task automatic t_busy;      run_xfer("R9 restart", 24'h000680, 32'hC00, 24'd62, 32'h100000, 1); endtask
  // R11 and R2 under stalls on a long misaligned run
  task automatic t_long;      run_xfer("R11 long", 24'h000046, 32'h2000, 24'd400, 32'h100000, 0); endtask

  initial begin
    for (int i = 0; i < MEM_N; i++) begin mem[i] = 8'hA5; exp_m[i] = 8'hA5; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_aligned();
    t_mask();
    t_multi();
    t_mis();
    t_offbyone();
    t_floor();
    t_oob();
    t_busy();
    t_long();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule